// File: doc/BRIEF.md
# Multi-Comparator Event Timer

This block is a memory-mapped event timer. It holds one free-running 64-bit main counter and a parameterised number of comparators, and each comparator can raise its own interrupt line. Software reaches it through a plain 32-bit register port with address, write data, write strobe, read strobe and read data. Every 64-bit register is split into a low word at its base offset and a high word at base plus 4, inside a 1024-byte window. A read strobe in one cycle returns the selected word on `bus_rdata` after the next rising clock edge. Writes take effect at the edge where the write strobe is sampled. The port has no back-pressure: every access completes in a single cycle.

Each comparator runs in one of two modes. In one-shot mode it fires once when the counter reaches a programmed absolute value. In periodic mode, which only periodic-capable comparators accept, a hidden period register advances the match time after every match. Periodic programming uses a value-set sequence. Writing the configuration with the value-set bit arms the comparator. The next completed value write then sets the next absolute match time, and the write after that sets the period. A comparator's interrupt is either a level line backed by a bit in a shared status register, cleared by writing 1, or a one-cycle edge pulse.

Top module: `evt_timer_top`

## Requirements
- R1: The capability low word holds the comparator count minus one in bits [12:8] and a 1 in bit 13, meaning a 64-bit counter. The capability high word (offset 0x004) returns the tick period in femtoseconds, given by parameter `TICK_FS`.
- R2: Bit 0 of the global configuration word (0x010) runs the main counter (0x0F0/0x0F4). While that bit is set the counter rises by exactly one per clock; while it is clear the counter holds its value.
- R3: A write to either counter word loads that half only while the counter is halted. The same write while the counter runs has no effect.
- R4: Comparator n has its configuration at 0x100+0x20·n and its value at 0x108+0x20·n. It matches when the counter is running and equals the value. Its interrupt output reacts at the clock edge after the cycle in which the counter holds the matching value. A one-shot comparator fires once per programmed value.
- R5: Configuration bit 1 selects level (1) or edge (0). In edge mode each match gives a pulse on `irq_o[n]` exactly one cycle wide, provided interrupt enable (bit 0) is set.
- R6: In level mode a match sets bit n of the status register (0x020) whether or not the interrupt is enabled. `irq_o[n]` is high while that bit is set and bit 0 is set, and stays low while bit 0 is clear.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: Configuration bit 3 is a read-only periodic-capable flag, set from parameter `PER_CAP_MASK`. The periodic bit (bit 2) can be set only when bit 3 is 1 and otherwise reads 0.
- R9: Writing the configuration with bit 4 (value-set) set arms the comparator. The next completed value write loads the match time, and the one after it loads the period. Bit 4 always reads 0. A value write is completed by a high-word write, or by a low-word write in 32-bit mode.
- R10: A periodic comparator adds its period to the match time on each match, so the matches come exactly one period apart.
- R11: With bit 5 (32-bit mode) set, only the low 32 counter bits are compared. High-word value writes are ignored, and the high value word reads 0.
- R12: After reset the counter, global enable, status and comparator values are zero and every interrupt output is low. Each comparator configuration reads only its constant bits: bit 3 as in R8 and bit 6 = 1 (64-bit capable).
- R13: The route field, bits [12:8] of the configuration, is stored and read back. The configuration high word reads the constant `ROUTE_CAP` and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_re | input | 1 | Read strobe; data appears after the next edge |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | N_CMP | Per-comparator interrupt lines |

## Verification
The hardest state to reach from the ports is the value-set sequence followed by several periodic matches. The bench must arm the comparator, complete a match-time write and then a period write, and observe the exact spacing between pulses while the counter runs freely. Before each scenario the bench halts the counter, zeroes it and parks every comparator. Match times then fall at known cycles counted from the enabling write. Random match times and periods drawn from a fixed seed exercise the interval arithmetic. The final match value is read back after halting to confirm the advance. The 32-bit mode case is reached by loading a counter with a nonzero high word, which a full-width compare can never match.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int CNT_W  = 64;
  localparam int HALF_W = CNT_W / 2;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;

  // comparator configuration word bit positions
  localparam int CB_IEN   = 0;
  localparam int CB_LVL   = 1;
  localparam int CB_PER   = 2;
  localparam int CB_PCAP  = 3;
  localparam int CB_VSET  = 4;
  localparam int CB_M32   = 5;
  localparam int CB_CAP64 = 6;
  localparam int RT_LSB   = 8;
  localparam int RT_W     = 5;

  // capability word fields
  localparam int CAP_NUM_LSB = 8;
  localparam int CAP_SZ_BIT  = 13;

  // register offsets
  localparam logic [ADDR_W-1:0] OFF_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_GCFG   = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_ISR    = 10'h020;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 10'h0F4;
  localparam logic [4:0]        CMP_BASE_SLOT = 5'd8;

  typedef enum logic [1:0] {
    VS_IDLE   = 2'd0,
    VS_MATCH  = 2'd1,
    VS_PERIOD = 2'd2
  } vs_state_t;
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter
  import evt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      if (wr_lo_i) cnt_q[HALF_W-1:0]     <= wdata_i;
      if (wr_hi_i) cnt_q[CNT_W-1:HALF_W] <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;

  // R2: a running counter steps by one and ignores writes (R3)
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2: a halted, unwritten counter holds
  a_r2_hold_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_cmp_unit.sv
module evt_cmp_unit
  import evt_timer_pkg::*;
#(
  parameter logic              PER_CAP   = 1'b0,
  parameter logic [DATA_W-1:0] ROUTE_CAP = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cnt_en_i,
  input  logic              cfg_we_i,
  input  logic              val_we_lo_i,
  input  logic              val_we_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              isr_clr_i,
  output logic [DATA_W-1:0] cfg_lo_o,
  output logic [DATA_W-1:0] cfg_hi_o,
  output logic [CNT_W-1:0]  val_o,
  output logic              status_o,
  output logic              irq_o
);
  logic            ien_q, lvl_q, per_q, m32_q;
  logic [RT_W-1:0] route_q;
  vs_state_t       vs_q;
  logic [CNT_W-1:0] match_q, period_q, next_match;
  logic            status_q, pulse_q;
  logic            hit, done_wr, to_period;

  assign hit = cnt_en_i &&
               (m32_q ? (cnt_i[HALF_W-1:0] == match_q[HALF_W-1:0]) : (cnt_i == match_q));
  assign done_wr   = (val_we_hi_i && !m32_q) || (val_we_lo_i && m32_q);
  assign to_period = (vs_q == VS_PERIOD);
  assign next_match = m32_q ? {{HALF_W{1'b0}}, match_q[HALF_W-1:0] + period_q[HALF_W-1:0]}
                            : match_q + period_q;

  // configuration fields
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q   <= 1'b0;
      lvl_q   <= 1'b0;
      per_q   <= 1'b0;
      m32_q   <= 1'b0;
      route_q <= '0;
    end else if (cfg_we_i) begin
      ien_q   <= wdata_i[CB_IEN];
      lvl_q   <= wdata_i[CB_LVL];
      per_q   <= wdata_i[CB_PER] & PER_CAP;
      m32_q   <= wdata_i[CB_M32];
      route_q <= wdata_i[RT_LSB +: RT_W];
    end
  end

  // value-set sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q <= VS_IDLE;
    end else if (cfg_we_i && wdata_i[CB_VSET]) begin
      vs_q <= VS_MATCH;
    end else if (done_wr) begin
      vs_q <= (vs_q == VS_MATCH) ? VS_PERIOD : VS_IDLE;
    end
  end

  // match time: software write first, then periodic advance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
    end else if (val_we_lo_i && !to_period) begin
      match_q[HALF_W-1:0] <= wdata_i;
      if (m32_q) match_q[CNT_W-1:HALF_W] <= '0;
    end else if (val_we_hi_i && !m32_q && !to_period) begin
      match_q[CNT_W-1:HALF_W] <= wdata_i;
    end else if (hit && per_q) begin
      match_q <= next_match;
    end
  end

  // hidden period register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
    end else if (val_we_lo_i && to_period) begin
      period_q[HALF_W-1:0] <= wdata_i;
      if (m32_q) period_q[CNT_W-1:HALF_W] <= '0;
    end else if (val_we_hi_i && !m32_q && to_period) begin
      period_q[CNT_W-1:HALF_W] <= wdata_i;
    end
  end

  // interrupt state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      if (hit && lvl_q)   status_q <= 1'b1;
      else if (isr_clr_i) status_q <= 1'b0;
      pulse_q <= hit && !lvl_q;
    end
  end

  always_comb begin
    cfg_lo_o = '0;
    cfg_lo_o[CB_IEN]   = ien_q;
    cfg_lo_o[CB_LVL]   = lvl_q;
    cfg_lo_o[CB_PER]   = per_q;
    cfg_lo_o[CB_PCAP]  = PER_CAP;
    cfg_lo_o[CB_M32]   = m32_q;
    cfg_lo_o[CB_CAP64] = 1'b1;
    cfg_lo_o[RT_LSB +: RT_W] = route_q;
  end

  assign cfg_hi_o = ROUTE_CAP;
  assign val_o    = m32_q ? {{HALF_W{1'b0}}, match_q[HALF_W-1:0]} : match_q;
  assign status_o = status_q;
  assign irq_o    = ien_q & (lvl_q ? status_q : pulse_q);

  // R4: nothing fires while the counter is halted
  a_r4_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en_i |=> (!$rose(status_q) && !pulse_q));

  // R7: a clear without a simultaneous match empties the status bit
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_clr_i && !hit) |=> !status_q);

  // R6: a set status bit persists until cleared
  a_r6_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !isr_clr_i) |=> status_q);

  // R9: the period write retires the value-set sequence
  a_r9_vs_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_q == VS_PERIOD && done_wr && !cfg_we_i) |=> (vs_q == VS_IDLE));

  generate
    if (!PER_CAP) begin : g_nocap
      // R8: a comparator without the capability never enters periodic mode
      a_r8_no_periodic: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> !per_q);
    end
  endgenerate
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
  import evt_timer_pkg::*;
#(
  parameter int                N_CMP        = 3,
  parameter logic [DATA_W-1:0] TICK_FS      = 32'd69841279,
  parameter logic [N_CMP-1:0]  PER_CAP_MASK = 3'b001,
  parameter logic [DATA_W-1:0] ROUTE_CAP    = 32'h00F0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_CMP-1:0]  irq_o
);
  localparam logic [DATA_W-1:0] CAP_LO =
    (DATA_W'(N_CMP - 1) << CAP_NUM_LSB) | (DATA_W'(1) << CAP_SZ_BIT);

  logic              aligned, in_cmp;
  logic [4:0]        cmp_slot;
  logic [2:0]        sub;
  logic              gen_q;
  logic [CNT_W-1:0]  cnt;
  logic [N_CMP-1:0]  status_vec;
  logic [DATA_W-1:0] cfg_lo_a [N_CMP];
  logic [DATA_W-1:0] cfg_hi_a [N_CMP];
  logic [CNT_W-1:0]  val_a    [N_CMP];
  logic [DATA_W-1:0] rd_next;
  logic              isr_we;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign in_cmp   = (bus_addr[ADDR_W-1:ADDR_W-2] != 2'b00);
  assign cmp_slot = bus_addr[ADDR_W-1:5] - CMP_BASE_SLOT;
  assign sub      = bus_addr[4:2];
  assign isr_we   = bus_we && aligned && (bus_addr == OFF_ISR);

  always_ff @(posedge clk) begin
    if (!rst_n)                                         gen_q <= 1'b0;
    else if (bus_we && aligned && bus_addr == OFF_GCFG) gen_q <= bus_wdata[0];
  end

  evt_main_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (gen_q),
    .wr_lo_i (bus_we && aligned && bus_addr == OFF_CNT_LO),
    .wr_hi_i (bus_we && aligned && bus_addr == OFF_CNT_HI),
    .wdata_i (bus_wdata),
    .cnt_o   (cnt)
  );

  generate
    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
      logic sel;
      assign sel = bus_we && aligned && in_cmp && (cmp_slot == 5'(i));
      evt_cmp_unit #(
        .PER_CAP   (PER_CAP_MASK[i]),
        .ROUTE_CAP (ROUTE_CAP)
      ) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt),
        .cnt_en_i    (gen_q),
        .cfg_we_i    (sel && sub == 3'd0),
        .val_we_lo_i (sel && sub == 3'd2),
        .val_we_hi_i (sel && sub == 3'd3),
        .wdata_i     (bus_wdata),
        .isr_clr_i   (isr_we && bus_wdata[i]),
        .cfg_lo_o    (cfg_lo_a[i]),
        .cfg_hi_o    (cfg_hi_a[i]),
        .val_o       (val_a[i]),
        .status_o    (status_vec[i]),
        .irq_o       (irq_o[i])
      );
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (!in_cmp) begin
        case (bus_addr)
          OFF_CAP_LO: rd_next = CAP_LO;
          OFF_CAP_HI: rd_next = TICK_FS;
          OFF_GCFG:   rd_next = DATA_W'(gen_q);
          OFF_ISR:    rd_next = DATA_W'(status_vec);
          OFF_CNT_LO: rd_next = cnt[HALF_W-1:0];
          OFF_CNT_HI: rd_next = cnt[CNT_W-1:HALF_W];
          default:    rd_next = '0;
        endcase
      end else begin
        for (int i = 0; i < N_CMP; i++) begin
          if (cmp_slot == 5'(i)) begin
            case (sub)
              3'd0:    rd_next = cfg_lo_a[i];
              3'd1:    rd_next = cfg_hi_a[i];
              3'd2:    rd_next = val_a[i][HALF_W-1:0];
              3'd3:    rd_next = val_a[i][CNT_W-1:HALF_W];
              default: rd_next = '0;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end

  // R12: no interrupt line is active right after reset
  a_r12_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0));
endmodule

// File: tb/evt_timer_top_tb_top.sv
module evt_timer_top_tb_top;
  localparam int N = 3;
  localparam logic [31:0] TICK = 32'd69841279;
  localparam logic [31:0] RCAP = 32'h00F0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  evt_timer_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [9:0] cfg_a(int n);  return 10'(32'h100 + 32'h20 * n); endfunction
  function automatic logic [9:0] val_a(int n);  return 10'(32'h108 + 32'h20 * n); endfunction
  function automatic logic [31:0] exp_cfg(bit ien, bit lvl, bit per, bit pcap, bit m32, int route);
    return 32'(ien) | (32'(lvl) << 1) | (32'(per) << 2) | (32'(pcap) << 3) |
           (32'(m32) << 5) | (32'h1 << 6) | (32'(route & 31) << 8);
  endfunction
  function automatic logic [31:0] exp_cap(int n);
    return (32'(n - 1) << 8) | (32'h1 << 13);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic park();
    wr(10'h010, 32'h0);
    for (int i = 0; i < N; i++) begin
      wr(cfg_a(i), 32'h0);
      wr(val_a(i), 32'hFFFF_FFFF);
      wr(val_a(i) + 10'h4, 32'hFFFF_FFFF);
    end
    wr(10'h020, 32'hFFFF_FFFF);
    wr(10'h0F0, 32'h0);
    wr(10'h0F4, 32'h0);
  endtask

  task automatic wait_first(int idx, output int k);
    k = 0;
    while (!irq_o[idx] && k < 400) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic wait_next(int idx, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!irq_o[idx] && k < 400);
  endtask

  initial begin
    logic [31:0] d;
    int k, m, p;
    void'($urandom(32'd7351));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state
    chk("R12 irq", 64'(irq_o), 64'h0);
    rd(10'h0F0, d); chk("R12 cnt lo", 64'(d), 64'h0);
    rd(10'h010, d); chk("R12 gcfg", 64'(d), 64'h0);
    rd(10'h020, d); chk("R12 isr", 64'(d), 64'h0);
    rd(cfg_a(0), d); chk("R12 cfg0", 64'(d), 64'(exp_cfg(0,0,0,1,0,0)));
    rd(cfg_a(1), d); chk("R12 cfg1", 64'(d), 64'(exp_cfg(0,0,0,0,0,0)));
    rd(val_a(2), d); chk("R12 val2", 64'(d), 64'h0);

    // R1: capability
    rd(10'h000, d); chk("R1 cap lo", 64'(d), 64'(exp_cap(N)));
    rd(10'h004, d); chk("R1 cap hi", 64'(d), 64'(TICK));

    // R13: route field and route capability
    wr(cfg_a(2), 32'(19) << 8);
    rd(cfg_a(2), d); chk("R13 route", 64'(d), 64'(exp_cfg(0,0,0,0,0,19)));
    wr(cfg_a(2) + 10'h4, 32'h0);
    rd(cfg_a(2) + 10'h4, d); chk("R13 route cap", 64'(d), 64'(RCAP));

    // R3: halted counter accepts writes
    wr(10'h0F0, 32'h0000_1234);
    wr(10'h0F4, 32'h0000_0005);
    rd(10'h0F0, d); chk("R3 cnt lo write", 64'(d), 64'h1234);
    rd(10'h0F4, d); chk("R3 cnt hi write", 64'(d), 64'h5);

    // R2: run lengths, random
    for (int it = 0; it < 5; it++) begin
      int n;
      n = 1 + int'($urandom % 30);
      park();
      wr(10'h010, 32'h1);
      repeat (n) @(negedge clk);
      wr(10'h010, 32'h0);
      rd(10'h0F0, d); chk("R2 count run", 64'(d), 64'(n + 1));
      repeat (3) @(negedge clk);
      rd(10'h0F0, d); chk("R2 count held", 64'(d), 64'(n + 1));
    end

    // R3: a write while running is ignored
    park();
    wr(10'h010, 32'h1);
    wr(10'h0F0, 32'h0000_5555);
    wr(10'h010, 32'h0);
    rd(10'h0F0, d); chk("R3 running write ignored", 64'(d), 64'h2);

    // R4 R5: one-shot edge, random match times
    for (int it = 0; it < 5; it++) begin
      m = 3 + int'($urandom % 40);
      park();
      wr(cfg_a(2), 32'h1);
      wr(val_a(2), 32'(m));
      wr(val_a(2) + 10'h4, 32'h0);
      wr(10'h010, 32'h1);
      wait_first(2, k);
      chk("R4 match cycle", 64'(k), 64'(m + 1));
      @(negedge clk);
      chk("R5 pulse width", 64'(irq_o[2]), 64'h0);
      repeat (20) @(negedge clk);
      chk("R4 fires once", 64'(irq_o[2]), 64'h0);
    end

    // R6 R7: level mode, gated and ungated
    park();
    wr(cfg_a(1), 32'h3);
    wr(val_a(1), 32'd7);
    wr(val_a(1) + 10'h4, 32'h0);
    wr(cfg_a(2), 32'h2);
    wr(val_a(2), 32'd7);
    wr(val_a(2) + 10'h4, 32'h0);
    wr(10'h010, 32'h1);
    wait_first(1, k);
    chk("R6 level match cycle", 64'(k), 64'd8);
    chk("R6 disabled line low", 64'(irq_o[2]), 64'h0);
    repeat (5) @(negedge clk);
    chk("R6 level holds", 64'(irq_o[1]), 64'h1);
    rd(10'h020, d); chk("R6 status bits", 64'(d), 64'h6);
    wr(10'h020, 32'h0);
    rd(10'h020, d); chk("R7 write zero no effect", 64'(d), 64'h6);
    wr(10'h020, 32'h2);
    rd(10'h020, d); chk("R7 write one clears", 64'(d), 64'h4);
    chk("R7 line drops", 64'(irq_o[1]), 64'h0);
    wr(10'h020, 32'h4);
    rd(10'h020, d); chk("R7 second clear", 64'(d), 64'h0);

    // R8: periodic needs the capability
    park();
    wr(cfg_a(1), 32'h5);
    rd(cfg_a(1), d); chk("R8 no cap", 64'(d), 64'(exp_cfg(1,0,0,0,0,0)));

    // R9 R10: value-set sequence and periodic advance, random
    for (int it = 0; it < 3; it++) begin
      m = 5 + int'($urandom % 30);
      p = 4 + int'($urandom % 10);
      park();
      wr(cfg_a(0), 32'h15);
      wr(val_a(0), 32'(m));
      wr(val_a(0) + 10'h4, 32'h0);
      wr(val_a(0), 32'(p));
      wr(val_a(0) + 10'h4, 32'h0);
      rd(cfg_a(0), d); chk("R9 value-set reads zero", 64'(d), 64'(exp_cfg(1,0,1,1,0,0)));
      rd(val_a(0), d); chk("R9 match time loaded", 64'(d), 64'(m));
      wr(10'h010, 32'h1);
      wait_first(0, k);
      chk("R10 first match", 64'(k), 64'(m + 1));
      wait_next(0, k);
      chk("R10 period gap 1", 64'(k), 64'(p));
      wait_next(0, k);
      chk("R10 period gap 2", 64'(k), 64'(p));
      wr(10'h010, 32'h0);
      rd(val_a(0), d); chk("R10 advanced match", 64'(d), 64'(m + 3 * p));
    end

    // R11: 32-bit mode compare on low half
    park();
    wr(cfg_a(2), 32'h21);
    wr(val_a(2), 32'd10);
    wr(val_a(2) + 10'h4, 32'd7);
    rd(val_a(2) + 10'h4, d); chk("R11 high reads zero", 64'(d), 64'h0);
    wr(10'h0F4, 32'h1);
    wr(10'h010, 32'h1);
    wait_first(2, k);
    chk("R11 low-half match", 64'(k), 64'd11);
    @(negedge clk);
    chk("R11 pulse width", 64'(irq_o[2]), 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule